// File: doc/BRIEF.md
# Byte-Lane Static RAM Behavioural Model

This block is a cycle-level stand-in for a 16-bit-wide asynchronous static RAM. It is meant to sit on a test board model in front of a memory controller under verification. All controls are active low: chip select, output enable and write enable, plus one select per byte lane. Each cycle the block sorts the pins into one of four modes: idle, outputs off, read or write. It then drives the lanes that the selects pick. When a lane's part of a write ends, it stores that byte.

A fast simulation clock samples the pins so that the overlap of the enables can be seen. A byte lane's write lasts as long as chip select, write enable and that lane's select are all low. The lane's write ends at the first sampled edge where any of the three is seen high. It stores the address and data that were present in the cycle before that edge. The data bus is split into an input, an output and one drive enable per lane. A low drive enable stands for a high-impedance lane. The full device uses ADDR_W = 17 (131,072 words). The default is kept smaller so that the storage stays small at elaboration.

Write tracker states: WR_IDLE (no lane in a write overlap) and WR_OPEN (at least one lane was in overlap in the previous cycle). Transitions: START (WR_IDLE to WR_OPEN when any lane enters overlap), HOLD (WR_OPEN to WR_OPEN while any lane is still in overlap; lanes that dropped out are stored), and CLOSE (WR_OPEN to WR_IDLE when no lane is in overlap; every lane that was open is stored).

Top module: `sram_bytelane_model`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits, addressed by `addr`. Bits 7:0 form the low lane and bits 15:8 form the high lane. The full-size device uses ADDR_W = 17.
- R2: When `cs_n` is high, or when both `lo_sel_n` and `hi_sel_n` are high, the block is idle: `dq_oe` is 2'b00 and no byte is stored.
- R3: With `cs_n` low, `wr_n` high and `rd_n` high, `dq_oe` is 2'b00 whatever the lane selects are.
- R4: With `cs_n` low, `wr_n` high and `rd_n` low, `dq_oe[0]` equals the inverse of `lo_sel_n` and `dq_oe[1]` equals the inverse of `hi_sel_n`. Each driven lane of `dq_o` carries that lane of the stored word at `addr`, in the same cycle.
- R5: While `cs_n` and `wr_n` are both low and any lane select is low, `dq_oe` is 2'b00 whatever the level of `rd_n`.
- R6: A lane's byte is stored at the first rising clock edge where its overlap (cs_n, wr_n and its lane select all low) is seen to have ended. The stored value is the `addr` and `dq_i` lane sampled at the edge before. Data applied during the terminating cycle is not stored, and nothing is stored while the overlap continues.
- R7: A byte whose lane select stays high during a write keeps its previous value.
- R8: Lanes end their writes independently. If one lane select rises while the other stays low, the first lane is stored at once. The second lane is stored later, from its own final cycle.
- R9: `wr_n` low while `cs_n` is high stores nothing.
- R10: While `rst_n` is low, any write overlap is discarded. An overlap that both starts and ends during reset stores nothing, and the first edge after reset stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the write tracker |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| lo_sel_n | input | 1 | Low byte lane select (bits 7:0), active low |
| hi_sel_n | input | 1 | High byte lane select (bits 15:8), active low |
| dq_i | input | 16 | Write data from the controller |
| dq_o | output | 16 | Read data toward the controller |
| dq_oe | output | 2 | Per-lane drive enable; bit 0 is the low lane, bit 1 is the high lane, 0 means high impedance |

## Verification
In one edge, the block can store one lane that is leaving its write and keep the other lane open. It can also store bytes on the same edge at which the pins switch to a read, so that the newly stored byte must appear at the output at once. The bench provokes both cases. Directed sequences release the lane selects one cycle apart and change the data in each cycle. Random sequences toggle every control on a small set of addresses, so that reads often follow a write's end. A behavioural reference keeps one stored-value flag per byte and compares drive enables and read data at every falling edge.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_NO_OUT = 2'd1,
        MODE_READ   = 2'd2,
        MODE_WRITE  = 2'd3
    } pin_mode_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_OPEN = 1'b1
    } wr_state_e;

endpackage

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_model_pkg::*;
(
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             lo_sel_n,
    input  logic             hi_sel_n,
    output pin_mode_e        mode,
    output logic [LANES-1:0] lane_sel,
    output logic [LANES-1:0] wr_lanes
);

    logic any_lane;

    always_comb begin
        lane_sel = ~{hi_sel_n, lo_sel_n};
        any_lane = |lane_sel;
        // Priority: idle, then write, then outputs off, then read
        if (cs_n || !any_lane) begin
            mode = MODE_IDLE;
        end else if (!wr_n) begin
            mode = MODE_WRITE;
        end else if (rd_n) begin
            mode = MODE_NO_OUT;
        end else begin
            mode = MODE_READ;
        end
        wr_lanes = (mode == MODE_WRITE) ? lane_sel : '0;
    end

endmodule

// File: rtl/sram_write_track.sv
module sram_write_track
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic [LANES-1:0]  commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [WORD_W-1:0] commit_data
);

    wr_state_e         state_q, state_d;
    logic [LANES-1:0]  open_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;

    // next-state: START, HOLD, CLOSE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (|wr_lanes) state_d = WR_OPEN;
            WR_OPEN: if (!(|wr_lanes)) state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            open_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            open_q  <= wr_lanes;
            addr_q  <= addr;
            data_q  <= din;
        end
    end

    // outputs: lanes that were open last cycle and are closed now
    always_comb begin
        commit      = '0;
        commit_addr = addr_q;
        commit_data = data_q;
        unique case (state_q)
            WR_IDLE: commit = '0;
            WR_OPEN: commit = open_q & ~wr_lanes;
        endcase
    end

    AST_COMMIT_AFTER_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit) |-> $past(|wr_lanes)); // R6

    AST_NO_COMMIT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_lanes) && (wr_lanes == $past(wr_lanes))) |-> (commit == '0)); // R6

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we_lane,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lane[g]) begin
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/sram_bytelane_model.sv
module sram_bytelane_model
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              lo_sel_n,
    input  logic              hi_sel_n,
    input  logic [15:0]       dq_i,
    output logic [15:0]       dq_o,
    output logic [1:0]        dq_oe
);

    pin_mode_e         mode;
    logic [LANES-1:0]  lane_sel;
    logic [LANES-1:0]  wr_lanes;
    logic [LANES-1:0]  commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [WORD_W-1:0] commit_data;
    logic [WORD_W-1:0] rdata;

    sram_pin_decode u_dec (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .lo_sel_n (lo_sel_n),
        .hi_sel_n (hi_sel_n),
        .mode     (mode),
        .lane_sel (lane_sel),
        .wr_lanes (wr_lanes)
    );

    sram_write_track #(.ADDR_W(ADDR_W)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_lanes    (wr_lanes),
        .addr        (addr),
        .din         (dq_i),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    sram_lane_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .we_lane (commit),
        .waddr   (commit_addr),
        .wdata   (commit_data),
        .raddr   (addr),
        .rdata   (rdata)
    );

    // output drive per mode
    always_comb begin
        dq_o = rdata;
        unique case (mode)
            MODE_IDLE:   dq_oe = '0;
            MODE_NO_OUT: dq_oe = '0;
            MODE_WRITE:  dq_oe = '0;
            MODE_READ:   dq_oe = lane_sel;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (lo_sel_n && hi_sel_n)) |-> (dq_oe == 2'b00)); // R2

    AST_NO_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_n && rd_n) |-> (dq_oe == 2'b00)); // R3

    AST_READ_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_n && !rd_n && !lo_sel_n) |-> dq_oe[0]); // R4

    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n) |-> (dq_oe == 2'b00)); // R5

    AST_DESELECT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (commit == '0)); // R9

endmodule

// File: tb/sram_bytelane_model_tb.sv
module sram_bytelane_model_tb;

    localparam int PERIOD = 10;
    localparam int AW     = 11;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, lo_sel_n = 1'b1, hi_sel_n = 1'b1;
    logic [15:0]   dq_i = '0;
    logic [15:0]   dq_o;
    logic [1:0]    dq_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state (R1: 2**AW words, two byte lanes)
    logic [7:0] ref_lo [DEPTH];
    logic [7:0] ref_hi [DEPTH];
    bit         ref_lo_set [DEPTH];
    bit         ref_hi_set [DEPTH];
    bit         prev_lo, prev_hi;
    logic [AW-1:0] prev_addr;
    logic [15:0]   prev_data;

    sram_bytelane_model #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_lo_set[i] = 0;
            ref_hi_set[i] = 0;
        end
        prev_lo = 0; prev_hi = 0; prev_addr = '0; prev_data = '0;
    end

    // behavioural reference: a lane stores when its overlap is seen to end
    always @(posedge clk) begin
        bit cur_lo, cur_hi;
        cur_lo = !cs_n && !wr_n && !lo_sel_n;
        cur_hi = !cs_n && !wr_n && !hi_sel_n;
        if (!rst_n) begin
            prev_lo = 0;
            prev_hi = 0;
        end else begin
            if (prev_lo && !cur_lo) begin
                ref_lo[prev_addr] = prev_data[7:0];
                ref_lo_set[prev_addr] = 1;
            end
            if (prev_hi && !cur_hi) begin
                ref_hi[prev_addr] = prev_data[15:8];
                ref_hi_set[prev_addr] = 1;
            end
            prev_lo = cur_lo;
            prev_hi = cur_hi;
        end
        prev_addr = addr;
        prev_data = dq_i;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [1:0] exp_oe;
            string tag;
            if (cs_n || (lo_sel_n && hi_sel_n)) begin
                exp_oe = 2'b00; tag = "R2 idle lanes";
            end else if (!wr_n) begin
                exp_oe = 2'b00; tag = "R5 write lanes";
            end else if (rd_n) begin
                exp_oe = 2'b00; tag = "R3 no-out lanes";
            end else begin
                exp_oe = {!hi_sel_n, !lo_sel_n}; tag = "R4 read lanes";
            end
            check(tag, {14'd0, dq_oe}, {14'd0, exp_oe});
            if (exp_oe[0] && ref_lo_set[addr])
                check("R6 low lane data", {8'd0, dq_o[7:0]}, {8'd0, ref_lo[addr]});
            if (exp_oe[1] && ref_hi_set[addr])
                check("R7 high lane data", {8'd0, dq_o[15:8]}, {8'd0, ref_hi[addr]});
        end
    end

    task automatic drive(input logic [AW-1:0] a, input logic c, input logic r,
                         input logic w, input logic lo, input logic hi,
                         input logic [15:0] d);
        @(negedge clk);
        #1;
        addr = a; cs_n = c; rd_n = r; wr_n = w; lo_sel_n = lo; hi_sel_n = hi; dq_i = d;
    endtask

    // drive a read of both lanes and check at the next falling edge
    task automatic read_word(input logic [AW-1:0] a, input string tag, input logic [15:0] exp);
        drive(a, 0, 0, 1, 0, 0, 16'h0);
        @(negedge clk);
        check(tag, dq_o, exp);
        check(tag, {14'd0, dq_oe}, 16'h0003);
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        check("R2 reset lanes off", {14'd0, dq_oe}, 16'h0);
        drive(0, 1, 1, 1, 1, 1, 0);
        rst_n = 1'b1;

        // R6: stores data of the cycle before the terminating edge
        drive(5, 0, 1, 0, 0, 0, 16'h1111);
        drive(5, 0, 0, 0, 0, 0, 16'h2222);
        check("R5 write with rd low", {14'd0, dq_oe}, 16'h0);
        drive(5, 0, 1, 1, 0, 0, 16'h3333);
        read_word(5, "R6 final data stored", 16'h2222);

        // R8: lanes end independently
        drive(6, 0, 1, 0, 0, 0, 16'h1234);
        drive(6, 0, 1, 0, 0, 1, 16'h5678);
        drive(6, 0, 1, 1, 1, 1, 16'h9ABC);
        read_word(6, "R8 split lane end", 16'h1278);

        // R7: low lane only
        drive(6, 0, 1, 0, 0, 1, 16'hBEEF);
        drive(6, 1, 1, 1, 1, 1, 16'h0);
        read_word(6, "R7 high byte kept", 16'h12EF);

        // R9: write enable without chip select
        drive(6, 1, 1, 0, 0, 0, 16'hFFFF);
        drive(6, 1, 1, 0, 0, 0, 16'hFFFF);
        drive(6, 1, 1, 1, 1, 1, 16'h0);
        read_word(6, "R9 deselected write ignored", 16'h12EF);

        // R2: both lanes off means no write
        drive(6, 0, 1, 0, 1, 1, 16'hAAAA);
        drive(6, 0, 1, 1, 1, 1, 16'h0);
        read_word(6, "R2 no-lane write ignored", 16'h12EF);

        // R3: outputs off
        drive(6, 0, 1, 1, 0, 0, 0);
        @(negedge clk);
        check("R3 outputs off", {14'd0, dq_oe}, 16'h0);

        // R4: single lane read
        drive(6, 0, 0, 1, 1, 0, 0);
        @(negedge clk);
        check("R4 high lane only", {14'd0, dq_oe}, 16'h0002);
        check("R4 high lane data", {8'd0, dq_o[15:8]}, 16'h0012);

        // R10: overlap during reset is discarded
        drive(7, 0, 1, 0, 0, 0, 16'h0101);
        drive(7, 1, 1, 1, 1, 1, 16'h0);
        drive(7, 0, 1, 0, 0, 0, 16'hAAAA);
        rst_n = 1'b0;
        drive(7, 0, 1, 0, 0, 0, 16'hAAAA);
        drive(7, 0, 1, 1, 0, 0, 16'hAAAA);
        drive(7, 1, 1, 1, 1, 1, 16'h0);
        rst_n = 1'b1;
        read_word(7, "R10 reset discards write", 16'h0101);

        // random traffic on a few addresses (R1 words compared per cycle)
        for (int k = 0; k < 3000; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 7)) | (k[0] ? AW'(DEPTH - 8) : AW'(0));
            drive(a, ($urandom_range(0, 5) == 0), $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
                  $urandom_range(0, 2) == 0, 16'($urandom));
        end
        drive(0, 1, 1, 1, 1, 1, 0);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule